// File: doc/BRIEF.md
# Generate/Capture Timer Channel

One timer channel built on an up/down counter of CW bits (8 to 32) and a companion load register. In generate mode the counter is preset from the load register. It runs until it wraps past its terminal value, which is all ones when counting up and all zeros when counting down. On that wrap it raises an event strobe and, if enabled, a one-clock generate pulse. It then either reloads the preset and carries on, or stops where it is.

In capture mode the same counter runs freely. A trigger pin is passed through a two-flop synchronizer, and the cycle in which the synchronized level enters its active state latches the current count into the load register. An auto-reload/hold control decides whether each capture overwrites the previous one, or whether the first capture is kept until it has been read.

A freeze input stops counting for debug, while triggers are still sampled and the load register can still be accessed. The channel is intended to sit behind a register block that owns the control bits and turns the event strobe into an interrupt flag.

Top module: `tmr_channel`

## Requirements
- R1: After reset, count_out and load_out are 0, event_out is 0, and gen_out sits at its inactive level (0 when GEN_HIGH=1, 1 when GEN_HIGH=0).
- R2: A clock edge with load_wr=1 puts load_wdata into load_out. A clock edge with load_req=1 copies the load register into count_out, and that edge raises no event.
- R3: Generate mode (capture_mode=0), counting down (count_down=1), auto_reload=1, run_en=1, preset L. event_out first rises L+1 clocks after counting starts, with count_out all ones. It then repeats every L+2 clocks.
- R4: Generate mode, counting up (count_down=0), auto_reload=1, preset L. The first event comes 2^CW-L clocks after counting starts, with count_out 0. Events then repeat every 2^CW-L+1 clocks.
- R5: With auto_reload=0, the wrap raises one event and the counter then holds the wrapped value. No further event follows until load_req is applied.
- R6: gen_out is active for exactly the one clock in which a generate-mode event_out is high, and only when gen_en=1. With gen_en=0 the event still fires but gen_out stays inactive.
- R7: With run_en=0 the counter does not change, and no event is raised, neither from a wrap nor from a capture.
- R8: While freeze=1 the count is held, but a capture still latches that held count.
- R9: Capture mode, capture_en=1, run_en=1. trig_in becomes active (1 when TRIG_HIGH=1, 0 when TRIG_HIGH=0) before clock edge k. The count shown between edges k+1 and k+2 is written to load_out at edge k+2, and event_out is high in the cycle after that edge.
- R10: Capture mode with auto_reload=0. After a capture, later captures still raise event_out but leave load_out unchanged, until a load_rd strobe. The capture after that strobe is stored.
- R11: Capture mode with auto_reload=1. Every capture overwrites load_out.
- R12: With capture_en=0 a trigger edge neither captures nor raises an event. A load_wr in the cycle a capture is detected takes priority over the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counter runs and events are allowed |
| load_req | input | 1 | Copy load register into counter |
| count_down | input | 1 | 1 = count down, 0 = count up |
| auto_reload | input | 1 | Generate: reload vs hold; capture: overwrite vs keep |
| capture_mode | input | 1 | 1 = capture mode, 0 = generate mode |
| capture_en | input | 1 | Enables trigger captures |
| gen_en | input | 1 | Enables the generate pulse |
| freeze | input | 1 | Halts counting |
| trig_in | input | 1 | Asynchronous capture trigger |
| load_wr | input | 1 | Write strobe for the load register |
| load_wdata | input | CW | Load register write data |
| load_rd | input | 1 | Marks the held capture as read |
| count_out | output | CW | Current count |
| load_out | output | CW | Load register contents |
| gen_out | output | 1 | Generate pulse, polarity set by GEN_HIGH |
| event_out | output | 1 | One-clock wrap or capture event strobe |

## Verification
A register write to the load register and a trigger capture can land on the same clock edge, since both target the load register. The bench times load_wr to the exact cycle in which the synchronized edge is detected. It then expects the written value in load_out while event_out still reports the capture. A second collision puts a capture inside a freeze window, where the held count must be the value that is latched. The interval sweeps cover every down-count preset of an 8-bit counter and a stride of up-count presets, and they compare event spacing against the closed-form interval.

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW        = 8,
  parameter bit TRIG_HIGH = 1'b1,
  parameter bit GEN_HIGH  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          load_req,
  input  logic          count_down,
  input  logic          auto_reload,
  input  logic          capture_mode,
  input  logic          capture_en,
  input  logic          gen_en,
  input  logic          freeze,
  input  logic          trig_in,
  input  logic          load_wr,
  input  logic [CW-1:0] load_wdata,
  input  logic          load_rd,
  output logic [CW-1:0] count_out,
  output logic [CW-1:0] load_out,
  output logic          gen_out,
  output logic          event_out
);
  localparam logic [CW-1:0] ONES = '1;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic TRIG_IDLE = ~TRIG_HIGH;

  logic [CW-1:0] cnt_q, load_q;
  logic reload_due_q, stopped_q, cap_full_q, evt_q, gen_q;
  logic sync1_q, sync2_q, prev_q;

  wire trig_now  = TRIG_HIGH ? sync2_q : ~sync2_q;
  wire trig_prev = TRIG_HIGH ? prev_q  : ~prev_q;
  wire trig_edge = trig_now & ~trig_prev;

  wire step     = run_en & ~freeze & ~stopped_q & ~load_req;
  wire at_term  = count_down ? (cnt_q == ZERO) : (cnt_q == ONES);
  wire expire   = step & ~capture_mode & ~reload_due_q & at_term;
  wire cap_hit  = capture_mode & capture_en & run_en & trig_edge;
  wire cap_take = cap_hit & (auto_reload | ~cap_full_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= TRIG_IDLE;
      sync2_q <= TRIG_IDLE;
      prev_q  <= TRIG_IDLE;
    end else begin
      sync1_q <= trig_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= ZERO;
      reload_due_q <= 1'b0;
      stopped_q    <= 1'b0;
    end else if (load_req) begin
      cnt_q        <= load_q;
      reload_due_q <= 1'b0;
      stopped_q    <= 1'b0;
    end else if (step) begin
      if (reload_due_q && !capture_mode) cnt_q <= load_q;
      else if (count_down)               cnt_q <= cnt_q - 1'b1;
      else                               cnt_q <= cnt_q + 1'b1;
      reload_due_q <= expire & auto_reload;
      if (expire && !auto_reload) stopped_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q     <= ZERO;
      cap_full_q <= 1'b0;
    end else begin
      if (load_wr)       load_q <= load_wdata;
      else if (cap_take) load_q <= cnt_q;
      if (cap_take && !load_wr) cap_full_q <= 1'b1;
      else if (load_rd)         cap_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      gen_q <= 1'b0;
    end else begin
      evt_q <= expire | cap_hit;
      gen_q <= expire & gen_en;
    end
  end

  assign count_out = cnt_q;
  assign load_out  = load_q;
  assign event_out = evt_q;
  assign gen_out   = GEN_HIGH ? gen_q : ~gen_q;

  a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
    load_req |=> cnt_q == $past(load_q));
  a_r5_hold_stays: assert property (@(posedge clk) disable iff (rst)
    (stopped_q && !load_req) |=> $stable(cnt_q));
  a_r6_gen_single: assert property (@(posedge clk) disable iff (rst)
    gen_q |=> !gen_q);
  a_r6_gen_with_event: assert property (@(posedge clk) disable iff (rst)
    gen_q |-> evt_q);
  a_r7_event_needs_run: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(run_en));
  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    (freeze && !load_req) |=> $stable(cnt_q));
  a_r10_hold_until_read: assert property (@(posedge clk) disable iff (rst)
    (capture_mode && !auto_reload && cap_full_q && !load_wr) |=> $stable(load_q));
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam int CW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic run_en = 0, load_req = 0, count_down = 0, auto_reload = 0, capture_mode = 0;
  logic capture_en = 0, gen_en = 0, freeze = 0, trig = 0, load_wr = 0, load_rd = 0;
  logic [CW-1:0] load_wdata = '0;
  logic [CW-1:0] count_out, load_out, count_n, load_n;
  logic gen_out, event_out, gen_n, event_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_channel #(.CW(CW), .TRIG_HIGH(1'b1), .GEN_HIGH(1'b1)) u_dut (
    .clk, .rst, .run_en, .load_req, .count_down, .auto_reload, .capture_mode,
    .capture_en, .gen_en, .freeze, .trig_in(trig), .load_wr, .load_wdata, .load_rd,
    .count_out, .load_out, .gen_out, .event_out);

  tmr_channel #(.CW(CW), .TRIG_HIGH(1'b0), .GEN_HIGH(1'b0)) u_dut_inv (
    .clk, .rst, .run_en, .load_req, .count_down, .auto_reload, .capture_mode,
    .capture_en, .gen_en, .freeze, .trig_in(~trig), .load_wr, .load_wdata, .load_rd,
    .count_out(count_n), .load_out(load_n), .gen_out(gen_n), .event_out(event_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic preset(input logic [CW-1:0] v);
    @(negedge clk); load_wr = 1; load_wdata = v;
    @(negedge clk); load_wr = 0; load_req = 1;
    @(negedge clk); load_req = 0;
  endtask

  task automatic run_gen(input int L, input bit dn);
    int first, per;
    logic [CW-1:0] at;
    bit g_ok;
    @(negedge clk);
    run_en = 0; count_down = dn; auto_reload = 1; capture_mode = 0; gen_en = 1;
    preset(L[CW-1:0]);
    chk(count_out == L[CW-1:0], "R2 load copy", count_out, L);
    run_en = 1;
    first = 0;
    do begin @(negedge clk); first++; end while (!event_out && first < 1000);
    at = count_out;
    g_ok = (gen_out == 1'b1) && (gen_n == 1'b0);
    per = 0;
    do begin @(negedge clk); per++; end while (!event_out && per < 1000);
    run_en = 0;
    if (dn) begin
      chk(first == L + 1, "R3 first event", first, L + 1);
      chk(per == L + 2, "R3 period", per, L + 2);
      chk(at == 8'hFF, "R3 wrap value", at, 255);
    end else begin
      chk(first == 256 - L, "R4 first event", first, 256 - L);
      chk(per == 257 - L, "R4 period", per, 257 - L);
      chk(at == 8'h00, "R4 wrap value", at, 0);
    end
    chk(g_ok, "R6 gen pulse and polarity", gen_out, 1);
  endtask

  task automatic do_cap(input bit wr, input logic [CW-1:0] wv,
                        output logic [CW-1:0] seen, output bit ev);
    @(negedge clk); trig = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); seen = count_out;
    if (wr) begin load_wr = 1; load_wdata = wv; end
    @(negedge clk); load_wr = 0; ev = event_out; trig = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [CW-1:0] s1, s2, s3, s4, s5, f, prev;
    bit ev;
    int evs;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(count_out == 0, "R1 count reset", count_out, 0);
    chk(load_out == 0, "R1 load reset", load_out, 0);
    chk(event_out == 0, "R1 event reset", event_out, 0);
    chk(gen_out == 0 && gen_n == 1, "R1 gen idle", gen_out, 0);

    for (int L = 0; L < 256; L++) run_gen(L, 1'b1);
    for (int L = 0; L < 256; L += 5) run_gen(L, 1'b0);
    run_gen(255, 1'b0);

    // R5 hold and R6 with gen disabled
    @(negedge clk); count_down = 1; auto_reload = 0; gen_en = 0;
    preset(8'd3);
    run_en = 1;
    repeat (4) @(negedge clk);
    chk(event_out == 1, "R5 event at wrap", event_out, 1);
    chk(gen_out == 0, "R6 gen disabled", gen_out, 0);
    chk(count_out == 8'hFF, "R5 wrapped value", count_out, 255);
    evs = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); evs += event_out; end
    chk(evs == 0, "R5 no more events", evs, 0);
    chk(count_out == 8'hFF, "R5 held", count_out, 255);
    run_en = 0;

    // R7 disabled counter
    preset(8'd10);
    evs = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); evs += event_out; end
    chk(count_out == 10, "R7 no count", count_out, 10);
    chk(evs == 0, "R7 no event", evs, 0);

    // R8 freeze in generate mode
    auto_reload = 1; preset(8'd20);
    run_en = 1;
    repeat (3) @(negedge clk);
    chk(count_out == 17, "R8 pre-freeze", count_out, 17);
    freeze = 1;
    repeat (5) @(negedge clk);
    chk(count_out == 17, "R8 frozen", count_out, 17);
    freeze = 0;
    @(negedge clk);
    chk(count_out == 16, "R8 resumes", count_out, 16);
    run_en = 0;

    // capture mode
    count_down = 0; auto_reload = 0; capture_mode = 1; capture_en = 1;
    preset(8'd0);
    run_en = 1; load_rd = 1;
    @(negedge clk); load_rd = 0;
    do_cap(0, 0, s1, ev);
    chk(load_out == s1, "R9 capture value", load_out, s1);
    chk(ev == 1, "R9 capture event", ev, 1);
    chk(load_n == load_out, "R9 low-true trigger", load_n, load_out);
    repeat (4) @(negedge clk);
    do_cap(0, 0, s2, ev);
    chk(load_out == s1, "R10 second capture dropped", load_out, s1);
    chk(ev == 1, "R10 event still fires", ev, 1);
    @(negedge clk); load_rd = 1;
    @(negedge clk); load_rd = 0;
    do_cap(0, 0, s3, ev);
    chk(load_out == s3, "R10 capture after read", load_out, s3);
    auto_reload = 1;
    do_cap(0, 0, s4, ev);
    chk(load_out == s4, "R11 overwrite first", load_out, s4);
    repeat (2) @(negedge clk);
    do_cap(0, 0, s5, ev);
    chk(load_out == s5, "R11 overwrite second", load_out, s5);
    chk(s5 != s4, "R11 distinct captures", s5, s4 + 1);

    freeze = 1;
    @(negedge clk); f = count_out;
    do_cap(0, 0, s1, ev);
    chk(load_out == f, "R8 capture while frozen", load_out, f);
    chk(count_out == f, "R8 count held", count_out, f);
    freeze = 0;

    capture_en = 0; prev = load_out;
    do_cap(0, 0, s1, ev);
    chk(ev == 0, "R12 no event when disabled", ev, 0);
    chk(load_out == prev, "R12 no capture when disabled", load_out, prev);
    capture_en = 1;

    do_cap(1, 8'hA5, s1, ev);
    chk(load_out == 8'hA5, "R12 write wins", load_out, 165);
    chk(ev == 1, "R12 capture event kept", ev, 1);
    chk(load_n == load_out, "R12 twin agrees", load_n, load_out);

    run_en = 0; prev = load_out;
    do_cap(0, 0, s1, ev);
    chk(ev == 0, "R7 no capture event", ev, 0);
    chk(load_out == prev, "R7 no capture", load_out, prev);
    finish_run();
  end
endmodule